// File: doc/BRIEF.md
# Multiblock Read Command Sequencer

This block controls the command-level sequence for a card read command that returns one or more data blocks. Software prepares the command, clears the receive FIFO and then strobes a start input. The sequencer asks the link layer to send the command and waits for a response. It then lets data blocks arrive one at a time. It can suspend between blocks, either on every block or when the FIFO is full, and it ends the sequence either by itself or on a software request. A software-requested end raises a request for a stop command.

The block has two ways of running a multiblock transfer. In open-ended mode, the sequence pauses after every block and waits for software to say "continue" or "stop". In preset mode, the sequence runs for a block count given at start. It stops only when the FIFO fills at a block boundary. A preset run that never paused ends cleanly with no stop command. A preset run that paused at least once asks for a stop command when it ends. Four sticky interrupt flags report command sent, response timeout, transfer end and FIFO full. A busy output covers the whole sequence.

Top module: `blkrd_top`

## Requirements
- R1: A start strobe is accepted only while the block is idle and a FIFO-clear strobe has arrived since reset or since the previous accepted start. Otherwise the start strobe is ignored and busy stays low.
- R2: From an accepted start until the command-sent handshake, cmd_req_o is high and data_en_o is low. The command-sent handshake sets the command-end flag, which is clear-vector bit 0.
- R3: If no response arrives within TMO_CYC clock cycles after the command has been sent, the timeout flag (clear-vector bit 1) is set and busy falls on the same edge. No data phase follows.
- R4: In open-ended mode (multi_i = 0), every received block sets the transfer-end flag (clear-vector bit 2) and suspends the sequence: data_en_o goes low and busy stays high.
- R5: In preset mode (multi_i = 1), a sequence that never suspended ends after the preset number of blocks. Busy falls, the transfer-end flag is set and no stop request is made.
- R6: A block received while fifo_full_i is high suspends a sequence that has blocks left to receive, and sets the FIFO-full flag (clear-vector bit 3).
- R7: A continue strobe during a suspension sets data_en_o high again. The remaining block count is kept.
- R8: A command-off strobe during a suspension ends the sequence. Busy falls, the transfer-end flag is set, and stop_req_o is high for exactly one cycle, the first cycle with busy low.
- R9: In preset mode, a sequence that suspended at least once ends at its last block with a one-cycle stop request.
- R10: Flags are sticky and cleared by writing ones to irq_clr_i. A set event in the same cycle as a clear wins.
- R11: Continue and command-off strobes that arrive outside a suspension have no effect.
- R12: After reset, busy, cmd_req_o, data_en_o, stop_req_o and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| fifo_clr_i | input | 1 | FIFO has been cleared (strobe) |
| cont_i | input | 1 | Continue strobe |
| cmdoff_i | input | 1 | Command-off strobe |
| multi_i | input | 1 | 0 open-ended, 1 preset count (latched at start) |
| blk_cnt_i | input | CNT_W | Preset block count (latched at start) |
| cmd_sent_i | input | 1 | Link reports command transmitted |
| resp_rcvd_i | input | 1 | Link reports response received |
| blk_rcvd_i | input | 1 | Link reports one data block received |
| fifo_full_i | input | 1 | FIFO full level |
| irq_clr_i | input | 4 | Write-one-to-clear for the flags |
| cmd_req_o | output | 1 | Send-command request |
| data_en_o | output | 1 | Data reception enabled |
| busy_o | output | 1 | Sequence in progress |
| stop_req_o | output | 1 | Stop-command request pulse |
| irq_cmd_end_o | output | 1 | Command-sent flag |
| irq_tmo_o | output | 1 | Response-timeout flag |
| irq_dte_o | output | 1 | Transfer-end flag |
| irq_ffull_o | output | 1 | FIFO-full flag |

## Verification
The assertions assume that the link handshakes are single-cycle pulses and that each one arrives only in the phase that expects it: command-sent while the command is requested, and a block only while data_en_o is high. They also assume that the preset count is at least one. The stimulus follows these rules. Every handshake is a one-cycle pulse, driven only after the bench has seen the matching phase at the outputs. Strobes sent outside their phase are used only to test that they are ignored.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RESP,
        ST_DATA,
        ST_SUSP
    } seq_state_e;

    typedef enum logic {
        MODE_OPEN   = 1'b0,
        MODE_PRESET = 1'b1
    } blk_mode_e;

    localparam int NFLAG = 4;

    // bit 0 cmd_end, bit 1 tmo, bit 2 dte, bit 3 ffull
    typedef struct packed {
        logic ffull;
        logic dte;
        logic tmo;
        logic cmd_end;
    } irq_vec_t;

    function automatic irq_vec_t irq_none();
        irq_vec_t v;
        v = '0;
        return v;
    endfunction

endpackage

// File: rtl/blkrd_tmo.sv
module blkrd_tmo #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(TMO_CYC - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == CW'(TMO_CYC - 1));
endmodule

// File: rtl/blkrd_blkcnt.sv
module blkrd_blkcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (dec_i && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign last_o = (rem_q <= CNT_W'(1));
endmodule

// File: rtl/blkrd_irq.sv
module blkrd_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)
                f_q <= 1'b0;
            else if (set_i[g])
                f_q <= 1'b1;
            else if (clr_i[g])
                f_q <= 1'b0;
        end
        assign flags_o[g] = f_q;
    end
endmodule

// File: rtl/blkrd_fsm.sv
module blkrd_fsm
    import blkrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       fifo_clr_i,
    input  logic       cont_i,
    input  logic       cmdoff_i,
    input  logic       multi_i,
    input  logic       cmd_sent_i,
    input  logic       resp_rcvd_i,
    input  logic       blk_rcvd_i,
    input  logic       fifo_full_i,
    input  logic       tmo_exp_i,
    input  logic       last_i,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       dec_o,
    output logic       run_tmo_o,
    output irq_vec_t   set_o,
    output logic       stop_req_o
);
    seq_state_e state_q, state_d;
    blk_mode_e  mode_q;
    logic       clr_ok_q, susp_seen_q, stop_q, stop_d;

    always_comb begin
        state_d = state_q;
        set_o   = irq_none();
        load_o  = 1'b0;
        dec_o   = 1'b0;
        stop_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && clr_ok_q) begin
                    state_d = ST_CMD;
                    load_o  = 1'b1;
                end
            end
            ST_CMD: begin
                if (cmd_sent_i) begin
                    set_o.cmd_end = 1'b1;
                    state_d       = ST_RESP;
                end
            end
            ST_RESP: begin
                if (resp_rcvd_i) begin
                    state_d = ST_DATA;
                end else if (tmo_exp_i) begin
                    set_o.tmo = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_DATA: begin
                if (blk_rcvd_i) begin
                    dec_o = 1'b1;
                    if (mode_q == MODE_PRESET && last_i) begin
                        set_o.dte = 1'b1;
                        stop_d    = susp_seen_q;
                        state_d   = ST_IDLE;
                    end else if (mode_q == MODE_OPEN) begin
                        set_o.dte   = 1'b1;
                        set_o.ffull = fifo_full_i;
                        state_d     = ST_SUSP;
                    end else if (fifo_full_i) begin
                        set_o.ffull = 1'b1;
                        state_d     = ST_SUSP;
                    end
                end
            end
            ST_SUSP: begin
                if (cmdoff_i) begin
                    set_o.dte = 1'b1;
                    stop_d    = 1'b1;
                    state_d   = ST_IDLE;
                end else if (cont_i) begin
                    state_d = ST_DATA;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_OPEN;
            clr_ok_q    <= 1'b0;
            susp_seen_q <= 1'b0;
            stop_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            stop_q  <= stop_d;
            if (load_o) begin
                mode_q      <= blk_mode_e'(multi_i);
                clr_ok_q    <= 1'b0;
                susp_seen_q <= 1'b0;
            end else begin
                if (fifo_clr_i) clr_ok_q <= 1'b1;
                if (state_d == ST_SUSP) susp_seen_q <= 1'b1;
            end
        end
    end

    assign state_o    = state_q;
    assign run_tmo_o  = (state_q == ST_RESP);
    assign stop_req_o = stop_q;
endmodule

// File: rtl/blkrd_top.sv
module blkrd_top
    import blkrd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TMO_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fifo_clr_i,
    input  logic             cont_i,
    input  logic             cmdoff_i,
    input  logic             multi_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    input  logic             cmd_sent_i,
    input  logic             resp_rcvd_i,
    input  logic             blk_rcvd_i,
    input  logic             fifo_full_i,
    input  logic [3:0]       irq_clr_i,
    output logic             cmd_req_o,
    output logic             data_en_o,
    output logic             busy_o,
    output logic             stop_req_o,
    output logic             irq_cmd_end_o,
    output logic             irq_tmo_o,
    output logic             irq_dte_o,
    output logic             irq_ffull_o
);
    seq_state_e       state;
    logic             load, dec, run_tmo, tmo_exp, last;
    irq_vec_t         set_vec;
    logic [NFLAG-1:0] flags;

    blkrd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .fifo_clr_i (fifo_clr_i),
        .cont_i     (cont_i),
        .cmdoff_i   (cmdoff_i),
        .multi_i    (multi_i),
        .cmd_sent_i (cmd_sent_i),
        .resp_rcvd_i(resp_rcvd_i),
        .blk_rcvd_i (blk_rcvd_i),
        .fifo_full_i(fifo_full_i),
        .tmo_exp_i  (tmo_exp),
        .last_i     (last),
        .state_o    (state),
        .load_o     (load),
        .dec_o      (dec),
        .run_tmo_o  (run_tmo),
        .set_o      (set_vec),
        .stop_req_o (stop_req_o)
    );

    blkrd_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run_tmo),
        .expired_o(tmo_exp)
    );

    blkrd_blkcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .load_val_i(blk_cnt_i),
        .dec_i     (dec),
        .last_o    (last)
    );

    blkrd_irq #(.N(NFLAG)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (irq_clr_i),
        .flags_o(flags)
    );

    assign busy_o        = (state != ST_IDLE);
    assign cmd_req_o     = (state == ST_CMD);
    assign data_en_o     = (state == ST_DATA);
    assign irq_cmd_end_o = flags[0];
    assign irq_tmo_o     = flags[1];
    assign irq_dte_o     = flags[2];
    assign irq_ffull_o   = flags[3];
endmodule

// File: rtl/blkrd_chk.sv
module blkrd_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic cmd_req_o,
    input logic data_en_o,
    input logic busy_o,
    input logic stop_req_o,
    input logic irq_tmo_o,
    input logic irq_dte_o
);
    AST_START_GATES_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)); // R1
    AST_CMDREQ_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
        cmd_req_o |-> busy_o); // R2
    AST_NO_PHASE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(cmd_req_o && data_en_o)); // R2
    AST_TMO_ENDS_SEQ: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_tmo_o) |-> !busy_o); // R3
    AST_END_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (irq_dte_o || irq_tmo_o)); // R5
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
        stop_req_o |-> (!busy_o && $past(busy_o))); // R8
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stop_req_o |=> !stop_req_o); // R8
endmodule

bind blkrd_top blkrd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .cmd_req_o (cmd_req_o),
    .data_en_o (data_en_o),
    .busy_o    (busy_o),
    .stop_req_o(stop_req_o),
    .irq_tmo_o (irq_tmo_o),
    .irq_dte_o (irq_dte_o)
);

// File: tb/blkrd_top_tb_top.sv
module blkrd_top_tb_top;
    localparam int CNT_W = 8;
    localparam int TMO   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, fifo_clr_i = 0, cont_i = 0, cmdoff_i = 0, multi_i = 0;
    logic [CNT_W-1:0] blk_cnt_i = '0;
    logic cmd_sent_i = 0, resp_rcvd_i = 0, blk_rcvd_i = 0, fifo_full_i = 0;
    logic [3:0] irq_clr_i = '0;
    logic cmd_req_o, data_en_o, busy_o, stop_req_o;
    logic irq_cmd_end_o, irq_tmo_o, irq_dte_o, irq_ffull_o;

    always #5 clk = ~clk;

    blkrd_top #(.CNT_W(CNT_W), .TMO_CYC(TMO)) dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed { logic stop; logic tmo; } end_item_t;
    end_item_t exp_q[$];

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        tick();
        s = 1'b0;
    endtask

    task automatic clr_all();
        irq_clr_i = 4'hF;
        tick();
        irq_clr_i = '0;
    endtask

    task automatic begin_seq(input logic mode, input int n);
        multi_i   = mode;
        blk_cnt_i = CNT_W'(n);
        pulse(fifo_clr_i);
        pulse(start_i);
        pulse(cmd_sent_i);
        pulse(resp_rcvd_i);
    endtask

    // Monitor: at each end of a sequence, compare against the next expected item
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (prev_busy && !busy_o) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8: unexpected end, actual stop=%0b expected none", stop_req_o);
            end else begin
                end_item_t e;
                e = exp_q.pop_front();
                check(32'(stop_req_o), 32'(e.stop), "R8/R9 stop request at end");
                check(32'(irq_tmo_o), 32'(e.tmo), "R3 timeout flag at end");
            end
        end
        prev_busy <= busy_o;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        check({busy_o, cmd_req_o, data_en_o, stop_req_o}, 0, "R12 outputs after reset");
        check({irq_ffull_o, irq_dte_o, irq_tmo_o, irq_cmd_end_o}, 0, "R12 flags after reset");

        // R1 start without FIFO clear ignored
        pulse(start_i);
        check(busy_o, 0, "R1 start without clear");

        // R1/R2/R11/R3 timeout sequence
        pulse(fifo_clr_i);
        pulse(start_i);
        check(busy_o, 1, "R1 start after clear");
        check(cmd_req_o, 1, "R2 command request");
        pulse(cont_i);
        check({cmd_req_o, data_en_o}, 2'b10, "R11 continue outside suspension");
        exp_q.push_back('{stop: 1'b0, tmo: 1'b1});
        pulse(cmd_sent_i);
        check({cmd_req_o, irq_cmd_end_o}, 2'b01, "R2 command end flag");
        repeat (TMO - 1) tick();
        check(busy_o, 1, "R3 busy before timeout");
        tick();
        check({busy_o, irq_tmo_o, data_en_o}, 3'b010, "R3 timeout ends sequence");
        clr_all();
        check({irq_ffull_o, irq_dte_o, irq_tmo_o, irq_cmd_end_o}, 0, "R10 write-one-to-clear");

        // Open-ended: R4, R10 set-wins, R7, R6, R8
        begin_seq(1'b0, 1);
        check(data_en_o, 1, "R2 data phase after response");
        irq_clr_i = 4'b0100;
        pulse(blk_rcvd_i);
        irq_clr_i = '0;
        check({busy_o, data_en_o, irq_dte_o}, 3'b101, "R4 R10 suspend after block, set wins");
        clr_all();
        pulse(cont_i);
        check(data_en_o, 1, "R7 continue resumes");
        fifo_full_i = 1'b1;
        pulse(blk_rcvd_i);
        fifo_full_i = 1'b0;
        check({data_en_o, irq_ffull_o, irq_dte_o}, 3'b011, "R6 FIFO full in open mode");
        exp_q.push_back('{stop: 1'b1, tmo: 1'b0});
        pulse(cmdoff_i);
        check({busy_o, stop_req_o, irq_dte_o}, 3'b011, "R8 command-off ends with stop");
        tick();
        check(stop_req_o, 0, "R8 stop is one cycle");
        clr_all();

        // Preset, no suspension: R5
        begin_seq(1'b1, 3);
        pulse(blk_rcvd_i);
        pulse(blk_rcvd_i);
        check({busy_o, data_en_o, irq_dte_o}, 3'b110, "R5 mid-transfer");
        exp_q.push_back('{stop: 1'b0, tmo: 1'b0});
        pulse(blk_rcvd_i);
        check({busy_o, irq_dte_o, stop_req_o}, 3'b010, "R5 preset end without stop");
        clr_all();

        // Preset with FIFO-full suspension: R6, R11, R7, R9
        begin_seq(1'b1, 3);
        pulse(cmdoff_i);
        check({busy_o, data_en_o, stop_req_o}, 3'b110, "R11 command-off outside suspension");
        fifo_full_i = 1'b1;
        pulse(blk_rcvd_i);
        fifo_full_i = 1'b0;
        check({data_en_o, irq_ffull_o, irq_dte_o}, 3'b010, "R6 preset suspend on FIFO full");
        pulse(cont_i);
        check(data_en_o, 1, "R7 resume preset");
        pulse(blk_rcvd_i);
        check({busy_o, data_en_o}, 2'b11, "R7 count kept");
        exp_q.push_back('{stop: 1'b1, tmo: 1'b0});
        pulse(blk_rcvd_i);
        check({busy_o, stop_req_o, irq_dte_o}, 3'b011, "R9 preset end with stop after suspension");
        tick();
        check(exp_q.size(), 0, "R8 all expected ends seen");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule